// File: doc/BRIEF.md
# Operand Bypass and Load Interlock Unit

This block is the purely combinational hazard logic that sits beside the execute stage of a five-stage in-order pipeline. Each cycle it compares the two source register numbers of the instruction about to execute against the destination numbers of the two older instructions still in flight, one in the memory stage and one in write-back. From that comparison it drives a select for each ALU operand multiplexer, so a result that has not yet reached the register file is bypassed straight to the ALU in the same cycle.

Bypassing cannot cover a load followed at once by an instruction that reads the loaded register, because the loaded data only appears at the end of the memory stage. For that case the block compares the load's target register with the two sources of the instruction in decode. On a match it asks the pipeline to hold the program counter and the fetch/decode register for one cycle, and to clear the control fields entering execute. This inserts one bubble. A write-back and a read of the same register in the same cycle are left to the register file, which is assumed to write before it reads.

Top module: `hazard_unit`

## Requirements
- R1: An operand select (encoding 2'b10) picks the memory-stage result when the memory-stage write enable is 1, its destination is not register 0, and the destination equals that operand's source register.
- R2: An operand select (encoding 2'b01) picks the write-back result when the write-back write enable is 1, its destination is not register 0, it equals the operand's source, and the R1 condition does not hold for that operand.
- R3: When both the memory-stage and the write-back destinations match an operand, the memory-stage result (2'b10) wins.
- R4: An operand select is 2'b00 (register file) when no stage with write enable 1 and a nonzero destination matches its source. A cleared write enable or a destination of register 0 never causes bypassing.
- R5: Operand A's select depends only on the execute-stage first source (rs). Operand B's select depends only on the execute-stage second source (rt). Each operand can take a different path in the same cycle.
- R6: When the execute-stage memory-read flag is 1 and the execute-stage rt equals either decode-stage source, the PC hold, fetch/decode hold and bubble outputs are all 1.
- R7: When the execute-stage memory-read flag is 0, all three stall outputs are 0, whatever the register numbers.
- R8: The three stall outputs always carry the same value. They are 0 when the memory-read flag is 1 but neither decode source matches.
- R9: All outputs are combinational functions of the present inputs. A new input pattern is reflected before the next clock edge, with no cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_rs_i | input | REG_ADDR_W | First source register of the instruction in execute |
| ex_rt_i | input | REG_ADDR_W | Second source register of the instruction in execute (load target when it is a load) |
| ex_memread_i | input | 1 | Instruction in execute reads data memory |
| mem_dst_i | input | REG_ADDR_W | Destination register of the instruction in the memory stage |
| mem_wen_i | input | 1 | Memory-stage instruction writes a register |
| wb_dst_i | input | REG_ADDR_W | Destination register of the instruction in write-back |
| wb_wen_i | input | 1 | Write-back instruction writes a register |
| id_rs_i | input | REG_ADDR_W | First source register of the instruction in decode |
| id_rt_i | input | REG_ADDR_W | Second source register of the instruction in decode |
| fwd_a_o | output | 2 | Operand A select: 00 register file, 10 memory stage, 01 write-back |
| fwd_b_o | output | 2 | Operand B select, same encoding |
| pc_hold_o | output | 1 | Keep the program counter unchanged this cycle |
| ifid_hold_o | output | 1 | Keep the fetch/decode register unchanged this cycle |
| bubble_o | output | 1 | Zero the control fields written into the execute-stage register |

## Verification
On every input change the assertions check several invariants. No select ever takes the unused code 11. A qualifying memory-stage match always yields 10, and a zero or disabled destination never yields a bypass. The three stall lines agree, and no stall appears without a load in execute. The bench scenarios show what those invariants cannot: the exact select for each mix of matching stages, that the two operands are resolved independently, that each decode source alone triggers the interlock, and that the 31st register behaves like any other.

// File: rtl/hazard_pkg.sv
package hazard_pkg;

   typedef enum logic [1:0] {
      FWD_REGFILE = 2'b00,
      FWD_WBACK   = 2'b01,
      FWD_MEMSTG  = 2'b10
   } fwd_sel_e;

endpackage

// File: rtl/hz_dst_match.sv
module hz_dst_match #(
   parameter int REG_ADDR_W = 5,
   parameter bit ZERO_REG_FIXED = 1'b1
) (
   input  logic [REG_ADDR_W-1:0] src_i,
   input  logic [REG_ADDR_W-1:0] dst_i,
   input  logic                  wen_i,
   output logic                  hit_o
);

   logic same_reg;
   assign same_reg = (src_i == dst_i);

   generate
      if (ZERO_REG_FIXED) begin : g_skip_zero
         // register 0 is hardwired, so a write to it never produces a value
         assign hit_o = wen_i && same_reg && (dst_i != '0);
      end else begin : g_plain
         assign hit_o = wen_i && same_reg;
      end
   endgenerate

endmodule

// File: rtl/hz_operand_fwd.sv
module hz_operand_fwd
   import hazard_pkg::*;
#(
   parameter int REG_ADDR_W = 5,
   parameter bit ZERO_REG_FIXED = 1'b1
) (
   input  logic [REG_ADDR_W-1:0] src_i,
   input  logic [REG_ADDR_W-1:0] mem_dst_i,
   input  logic                  mem_wen_i,
   input  logic [REG_ADDR_W-1:0] wb_dst_i,
   input  logic                  wb_wen_i,
   output fwd_sel_e              sel_o
);

   logic mem_hit;
   logic wb_hit;

   hz_dst_match #(.REG_ADDR_W(REG_ADDR_W), .ZERO_REG_FIXED(ZERO_REG_FIXED)) u_mem_cmp (
      .src_i (src_i),
      .dst_i (mem_dst_i),
      .wen_i (mem_wen_i),
      .hit_o (mem_hit)
   );

   hz_dst_match #(.REG_ADDR_W(REG_ADDR_W), .ZERO_REG_FIXED(ZERO_REG_FIXED)) u_wb_cmp (
      .src_i (src_i),
      .dst_i (wb_dst_i),
      .wen_i (wb_wen_i),
      .hit_o (wb_hit)
   );

   // the memory-stage value is younger, so it outranks write-back
   always_comb begin
      if (mem_hit)     sel_o = FWD_MEMSTG;
      else if (wb_hit) sel_o = FWD_WBACK;
      else             sel_o = FWD_REGFILE;
   end

endmodule

// File: rtl/hz_load_use.sv
module hz_load_use #(
   parameter int REG_ADDR_W = 5
) (
   input  logic                  ex_memread_i,
   input  logic [REG_ADDR_W-1:0] ex_rt_i,
   input  logic [REG_ADDR_W-1:0] id_rs_i,
   input  logic [REG_ADDR_W-1:0] id_rt_i,
   output logic                  stall_o
);

   logic rs_dep;
   logic rt_dep;

   assign rs_dep  = (ex_rt_i == id_rs_i);
   assign rt_dep  = (ex_rt_i == id_rt_i);
   assign stall_o = ex_memread_i && (rs_dep || rt_dep);

endmodule

// File: rtl/hazard_unit.sv
module hazard_unit
   import hazard_pkg::*;
#(
   parameter int REG_ADDR_W = 5,
   parameter bit ZERO_REG_FIXED = 1'b1
) (
   input  logic [REG_ADDR_W-1:0] ex_rs_i,
   input  logic [REG_ADDR_W-1:0] ex_rt_i,
   input  logic                  ex_memread_i,
   input  logic [REG_ADDR_W-1:0] mem_dst_i,
   input  logic                  mem_wen_i,
   input  logic [REG_ADDR_W-1:0] wb_dst_i,
   input  logic                  wb_wen_i,
   input  logic [REG_ADDR_W-1:0] id_rs_i,
   input  logic [REG_ADDR_W-1:0] id_rt_i,
   output logic [1:0]            fwd_a_o,
   output logic [1:0]            fwd_b_o,
   output logic                  pc_hold_o,
   output logic                  ifid_hold_o,
   output logic                  bubble_o
);

   localparam int NUM_OPS = 2;

   generate
      if (REG_ADDR_W < 1 || REG_ADDR_W > 8) begin : g_bad_width
         $error("hazard_unit: REG_ADDR_W must lie in 1..8");
      end
   endgenerate

   logic [REG_ADDR_W-1:0] op_src [NUM_OPS];
   fwd_sel_e              op_sel [NUM_OPS];
   logic                  lu_stall;

   assign op_src[0] = ex_rs_i;
   assign op_src[1] = ex_rt_i;

   generate
      for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
         hz_operand_fwd #(.REG_ADDR_W(REG_ADDR_W), .ZERO_REG_FIXED(ZERO_REG_FIXED)) u_fwd (
            .src_i     (op_src[g]),
            .mem_dst_i (mem_dst_i),
            .mem_wen_i (mem_wen_i),
            .wb_dst_i  (wb_dst_i),
            .wb_wen_i  (wb_wen_i),
            .sel_o     (op_sel[g])
         );
      end
   endgenerate

   hz_load_use #(.REG_ADDR_W(REG_ADDR_W)) u_lu (
      .ex_memread_i (ex_memread_i),
      .ex_rt_i      (ex_rt_i),
      .id_rs_i      (id_rs_i),
      .id_rt_i      (id_rt_i),
      .stall_o      (lu_stall)
   );

   assign fwd_a_o     = op_sel[0];
   assign fwd_b_o     = op_sel[1];
   assign pc_hold_o   = lu_stall;
   assign ifid_hold_o = lu_stall;
   assign bubble_o    = lu_stall;

endmodule

// File: rtl/hazard_unit_chk.sv
module hazard_unit_chk #(
   parameter int REG_ADDR_W = 5,
   parameter bit ZERO_REG_FIXED = 1'b1
) (
   input logic [REG_ADDR_W-1:0] ex_rs_i,
   input logic [REG_ADDR_W-1:0] ex_rt_i,
   input logic                  ex_memread_i,
   input logic [REG_ADDR_W-1:0] mem_dst_i,
   input logic                  mem_wen_i,
   input logic [REG_ADDR_W-1:0] wb_dst_i,
   input logic                  wb_wen_i,
   input logic [REG_ADDR_W-1:0] id_rs_i,
   input logic [REG_ADDR_W-1:0] id_rt_i,
   input logic [1:0]            fwd_a_o,
   input logic [1:0]            fwd_b_o,
   input logic                  pc_hold_o,
   input logic                  ifid_hold_o,
   input logic                  bubble_o
);

   always_comb begin
      p_sel_legal_r1: assert (fwd_a_o != 2'b11 && fwd_b_o != 2'b11)
         else $error("select took unused code");

      if (mem_wen_i && (!ZERO_REG_FIXED || mem_dst_i != '0) && mem_dst_i == ex_rs_i)
         p_mem_wins_a_r3: assert (fwd_a_o == 2'b10)
            else $error("operand A ignored memory-stage match");

      if (!mem_wen_i && !wb_wen_i)
         p_no_writer_r4: assert (fwd_a_o == 2'b00 && fwd_b_o == 2'b00)
            else $error("bypass without any writing stage");

      if (ZERO_REG_FIXED && ex_rt_i == '0)
         p_zero_src_r4: assert (fwd_b_o == 2'b00)
            else $error("register 0 bypassed on operand B");

      p_stall_agree_r8: assert (pc_hold_o == ifid_hold_o && ifid_hold_o == bubble_o)
         else $error("stall outputs disagree");

      if (!ex_memread_i)
         p_no_load_no_stall_r7: assert (!bubble_o)
            else $error("stall without a load in execute");

      if (ex_memread_i && (ex_rt_i == id_rs_i || ex_rt_i == id_rt_i))
         p_load_use_r6: assert (pc_hold_o)
            else $error("missed load-use dependency");
   end

endmodule

bind hazard_unit hazard_unit_chk #(
   .REG_ADDR_W     (REG_ADDR_W),
   .ZERO_REG_FIXED (ZERO_REG_FIXED)
) u_chk (
   .ex_rs_i      (ex_rs_i),
   .ex_rt_i      (ex_rt_i),
   .ex_memread_i (ex_memread_i),
   .mem_dst_i    (mem_dst_i),
   .mem_wen_i    (mem_wen_i),
   .wb_dst_i     (wb_dst_i),
   .wb_wen_i     (wb_wen_i),
   .id_rs_i      (id_rs_i),
   .id_rt_i      (id_rt_i),
   .fwd_a_o      (fwd_a_o),
   .fwd_b_o      (fwd_b_o),
   .pc_hold_o    (pc_hold_o),
   .ifid_hold_o  (ifid_hold_o),
   .bubble_o     (bubble_o)
);

// File: tb/hazard_unit_tb.sv
module hazard_unit_tb;

   localparam int W = 5;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #5 clk = ~clk;

   logic [W-1:0] ex_rs = '0, ex_rt = '0, mem_dst = '0, wb_dst = '0, id_rs = '0, id_rt = '0;
   logic         ex_memread = 1'b0, mem_wen = 1'b0, wb_wen = 1'b0;
   logic [1:0]   fwd_a, fwd_b;
   logic         pc_hold, ifid_hold, bubble;

   hazard_unit #(.REG_ADDR_W(W)) u_dut (
      .ex_rs_i      (ex_rs),
      .ex_rt_i      (ex_rt),
      .ex_memread_i (ex_memread),
      .mem_dst_i    (mem_dst),
      .mem_wen_i    (mem_wen),
      .wb_dst_i     (wb_dst),
      .wb_wen_i     (wb_wen),
      .id_rs_i      (id_rs),
      .id_rt_i      (id_rt),
      .fwd_a_o      (fwd_a),
      .fwd_b_o      (fwd_b),
      .pc_hold_o    (pc_hold),
      .ifid_hold_o  (ifid_hold),
      .bubble_o     (bubble)
   );

   typedef struct {
      logic [1:0] a;
      logic [1:0] b;
      logic       stall;
      string      tag;
   } exp_t;

   exp_t exp_q [$];
   int   n_checks = 0;
   int   n_fails  = 0;
   bit   done     = 1'b0;

   task automatic apply(input logic [W-1:0] rs, input logic [W-1:0] rt,
                        input logic [W-1:0] mdst, input logic mwen,
                        input logic [W-1:0] wdst, input logic wwen,
                        input logic mrd, input logic [W-1:0] irs, input logic [W-1:0] irt,
                        input logic [1:0] ea, input logic [1:0] eb, input logic es,
                        input string tag);
      exp_t e;
      @(posedge clk);
      #1;
      ex_rs = rs; ex_rt = rt; mem_dst = mdst; mem_wen = mwen;
      wb_dst = wdst; wb_wen = wwen; ex_memread = mrd; id_rs = irs; id_rt = irt;
      e.a = ea; e.b = eb; e.stall = es; e.tag = tag;
      exp_q.push_back(e);
   endtask

   // monitor: half a cycle after each drive, with no clock edge in between (R9)
   always @(negedge clk) begin
      if (exp_q.size() > 0) begin
         exp_t e;
         e = exp_q.pop_front();
         n_checks++;
         if (fwd_a !== e.a || fwd_b !== e.b || pc_hold !== e.stall ||
             ifid_hold !== e.stall || bubble !== e.stall) begin
            n_fails++;
            $display("FAIL %s: got a=%b b=%b hold=%b/%b bubble=%b, expected a=%b b=%b stall=%b",
                     e.tag, fwd_a, fwd_b, pc_hold, ifid_hold, bubble, e.a, e.b, e.stall);
         end
      end
   end

   initial begin
      repeat (2) @(posedge clk);
      rst = 1'b0;
      //     rs  rt  mdst mw wdst ww mrd irs irt   a      b     st  tag
      apply(0,  0,  0,   0, 0,   0, 0,  0,  0,   2'b00, 2'b00, 0, "R4 idle/reset state");
      apply(3,  1,  3,   1, 0,   0, 0,  2,  2,   2'b10, 2'b00, 0, "R1 mem-stage to A");
      apply(1,  3,  3,   1, 0,   0, 0,  2,  2,   2'b00, 2'b10, 0, "R1 mem-stage to B");
      apply(4,  1,  2,   1, 4,   1, 0,  2,  2,   2'b01, 2'b00, 0, "R2 write-back to A");
      apply(5,  5,  5,   1, 5,   1, 0,  2,  2,   2'b10, 2'b10, 0, "R3 mem-stage priority");
      apply(5,  1,  5,   0, 5,   1, 0,  2,  2,   2'b01, 2'b00, 0, "R4 mem write disabled");
      apply(0,  0,  0,   1, 0,   1, 0,  2,  2,   2'b00, 2'b00, 0, "R4 register 0 never bypassed");
      apply(10, 1,  9,   1, 11,  1, 0,  2,  2,   2'b00, 2'b00, 0, "R4 no match");
      apply(6,  7,  6,   1, 7,   1, 0,  2,  2,   2'b10, 2'b01, 0, "R5 independent operands");
      apply(7,  6,  6,   1, 7,   1, 0,  2,  2,   2'b01, 2'b10, 0, "R5 swapped operands");
      apply(1,  8,  0,   0, 0,   0, 1,  8,  2,   2'b00, 2'b00, 1, "R6 load-use via decode rs");
      apply(1,  8,  0,   0, 0,   0, 1,  3,  8,   2'b00, 2'b00, 1, "R6 load-use via decode rt");
      apply(1,  8,  0,   0, 0,   0, 0,  8,  8,   2'b00, 2'b00, 0, "R7 no load, no stall");
      apply(1,  8,  0,   0, 0,   0, 1,  3,  4,   2'b00, 2'b00, 0, "R8 load without dependency");
      apply(31, 31, 31,  1, 30,  1, 1,  31, 0,   2'b10, 2'b10, 1, "R1 R6 top register number");
      apply(30, 2,  31,  1, 30,  1, 0,  2,  2,   2'b01, 2'b00, 0, "R2 R9 next pattern settles");
      @(posedge clk);
      @(posedge clk);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         n_fails++;
         $display("FAIL watchdog: got timeout, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
         $finish;
      end
   end

endmodule